// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the write port of a NOR flash array controller. It watches each accepted bus write, which carries a 20-bit word address and a data word, and recognises the unlock-prefixed command sequences and the short one-cycle commands. When a sequence completes, it raises a single-cycle request that names the operation and carries the address and data of the final write. The embedded algorithms that carry out the operations and time them are outside this block.

Multi-cycle commands begin with a two-write unlock pair. The third write picks the command. An 80h selector opens a second unlock pair, and the sixth write then picks between the erase, lock and single-pulse-entry operations. Suspend, resume and identification exit each take one write. A sticky single-pulse mode turns every later write into a program request until reset. While the external busy flag is high, writes are dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock pair is data 0xAA at address 0x555, then data 0x55 at address 0x2AA. Only address bits 10..0 and data bits 7..0 are compared, so address bit 11, bits above it and data bits 15..8 do not matter.
- R2: After an unlock pair and 0xA0 at 0x555, the next write raises a program request (req_op=1) that carries that write's address and data.
- R3: After an unlock pair, 0x90 at 0x555 raises identification entry (req_op=7), and 0xF0 at 0x555 raises identification exit (req_op=8).
- R4: After an unlock pair, 0x80 at 0x555 and a second unlock pair, 0x10 at 0x555 raises chip erase (req_op=2).
- R5: At the same sixth write, 0x30 at any address raises sector erase (req_op=3), and 0x60 at any address raises sector lock (req_op=4). The address is carried out.
- R6: In the idle state, after the first write of either unlock pair, or after the 0x80 selector, a write of 0xB0 raises erase suspend (req_op=5), 0x30 raises erase resume (req_op=6) and 0xF0 raises identification exit (req_op=8), each at any address.
- R7: After an unlock pair and 0xC0 at 0x555, a write to any address other than 0x080 raises protection-register program (req_op=9). A write to 0x080 with data bit 1 clear raises protection lock (req_op=10). A write to 0x080 with data bit 1 set raises nothing.
- R8: At the sixth write, 0xA0 at 0x555 raises single-pulse entry (req_op=11) and sets single_mode. While single_mode is set, every accepted write raises a program request, whatever its data.
- R9: single_mode is cleared only by reset.
- R10: A write made while prog_busy is high raises no request and leaves the sequence position unchanged.
- R11: A write that does not fit the expected sequence returns the decoder to idle and raises no request.
- R12: A request appears on the clock edge that accepts the final write and lasts one cycle. After reset, req_valid and single_mode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| prog_busy | input | 1 | Embedded program in progress; writes are dropped |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Operation code, as listed in the requirements |
| req_addr | output | 20 | Address of the final write |
| req_data | output | 16 | Data of the final write |
| single_mode | output | 1 | Single-pulse program mode is active |

## Verification
Two functions can claim the same write. The first is the one-cycle commands against the sequence tracker. The second is single-pulse mode against every command decode. The bench sends 0xB0 in the middle of an unlock pair and checks that a suspend comes out and that the pair is dropped. After entering single-pulse mode, it sends an unlock write, a suspend code and a chip-erase code, and expects each to come out as a plain program request with its own address and data. A busy-flagged write placed in the middle of a sequence checks that the busy flag has priority over both functions.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_PROGRAM  = 4'd1,
    OP_CHIP_ERS = 4'd2,
    OP_SECT_ERS = 4'd3,
    OP_SECT_LCK = 4'd4,
    OP_SUSPEND  = 4'd5,
    OP_RESUME   = 4'd6,
    OP_ID_ENTER = 4'd7,
    OP_ID_EXIT  = 4'd8,
    OP_PR_PROG  = 4'd9,
    OP_PR_LOCK  = 4'd10,
    OP_SP_ENTER = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG_DATA,
    ST_PREG_DATA,
    ST_ERS_SEL,
    ST_ERS_KEY1,
    ST_ERS_KEY2
  } seq_e;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ID_IN   = 8'h90;
  localparam logic [7:0] CODE_ID_OUT  = 8'hF0;
  localparam logic [7:0] CODE_PREG    = 8'hC0;
  localparam logic [7:0] CODE_EXTEND  = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_LOCK    = 8'h60;
  localparam logic [7:0] CODE_SUSPEND = 8'hB0;

endpackage

// File: rtl/fcd_pattern.sv
module fcd_pattern #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_key_a,
  output logic              hit_key_b,
  output logic              hit_preg_lock,
  output logic [7:0]        code
);
  localparam logic [CMP_W-1:0] ADDR_KEY_A = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] ADDR_KEY_B = CMP_W'(12'h2AA);
  localparam logic [CMP_W-1:0] ADDR_PREG  = CMP_W'(12'h080);

  logic [CMP_W-1:0] low_addr;

  always_comb begin
    low_addr      = addr[CMP_W-1:0];
    code          = data[7:0];
    hit_key_a     = (low_addr == ADDR_KEY_A);
    hit_key_b     = (low_addr == ADDR_KEY_B);
    hit_preg_lock = (low_addr == ADDR_PREG);
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       hit_key_a,
  input  logic       hit_key_b,
  input  logic       hit_preg_lock,
  input  logic [7:0] code,
  input  logic       lock_bit,
  output logic       fire,
  output op_e        fire_op,
  output logic       sp_mode
);
  seq_e st_q, st_d;
  logic sp_q, sp_d;
  logic oneshot_ok;

  always_comb begin
    oneshot_ok = (st_q == ST_IDLE) || (st_q == ST_KEY1) ||
                 (st_q == ST_ERS_SEL) || (st_q == ST_ERS_KEY1);
  end

  always_comb begin
    st_d    = st_q;
    sp_d    = sp_q;
    fire    = 1'b0;
    fire_op = OP_NONE;
    if (wr_en) begin
      if (sp_q) begin
        fire    = 1'b1;
        fire_op = OP_PROGRAM;
      end else begin
        st_d = ST_IDLE;
        if (oneshot_ok && (code == CODE_SUSPEND)) begin
          fire = 1'b1; fire_op = OP_SUSPEND;
        end else if (oneshot_ok && (code == CODE_SECTOR)) begin
          fire = 1'b1; fire_op = OP_RESUME;
        end else if (oneshot_ok && (code == CODE_ID_OUT)) begin
          fire = 1'b1; fire_op = OP_ID_EXIT;
        end else begin
          unique case (st_q)
            ST_IDLE:  if (hit_key_a && code == CODE_KEY_A) st_d = ST_KEY1;
            ST_KEY1:  if (hit_key_b && code == CODE_KEY_B) st_d = ST_KEY2;
            ST_KEY2: begin
              if (hit_key_a) begin
                case (code)
                  CODE_PROG:   st_d = ST_PROG_DATA;
                  CODE_PREG:   st_d = ST_PREG_DATA;
                  CODE_EXTEND: st_d = ST_ERS_SEL;
                  CODE_ID_IN:  begin fire = 1'b1; fire_op = OP_ID_ENTER; end
                  CODE_ID_OUT: begin fire = 1'b1; fire_op = OP_ID_EXIT;  end
                  default:     st_d = ST_IDLE;
                endcase
              end
            end
            ST_PROG_DATA: begin fire = 1'b1; fire_op = OP_PROGRAM; end
            ST_PREG_DATA: begin
              if (!hit_preg_lock) begin
                fire = 1'b1; fire_op = OP_PR_PROG;
              end else if (!lock_bit) begin
                fire = 1'b1; fire_op = OP_PR_LOCK;
              end
            end
            ST_ERS_SEL:  if (hit_key_a && code == CODE_KEY_A) st_d = ST_ERS_KEY1;
            ST_ERS_KEY1: if (hit_key_b && code == CODE_KEY_B) st_d = ST_ERS_KEY2;
            ST_ERS_KEY2: begin
              case (code)
                CODE_CHIP:   if (hit_key_a) begin fire = 1'b1; fire_op = OP_CHIP_ERS; end
                CODE_SECTOR: begin fire = 1'b1; fire_op = OP_SECT_ERS; end
                CODE_LOCK:   begin fire = 1'b1; fire_op = OP_SECT_LCK; end
                CODE_PROG:   if (hit_key_a) begin
                               fire = 1'b1; fire_op = OP_SP_ENTER; sp_d = 1'b1;
                             end
                default:     st_d = ST_IDLE;
              endcase
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      sp_q <= 1'b0;
    end else if (wr_en) begin
      st_q <= st_d;
      sp_q <= sp_d;
    end
  end

  assign sp_mode = sp_q;

  // R9: once set, single-pulse mode holds until reset
  a_r9_single_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q |=> sp_q);

  // R10: a dropped write leaves the sequence position untouched
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st_q));

  // R11: a completed or broken command always returns to idle
  a_r11_fire_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sp_q) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int CMP_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_busy,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              single_mode
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic       wr_en;
  logic       hit_key_a, hit_key_b, hit_preg_lock;
  logic [7:0] code;
  logic       fire;
  op_e        fire_op;

  assign wr_en = wr_valid && !prog_busy;

  fcd_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) pat_i (
    .addr          (wr_addr),
    .data          (wr_data),
    .hit_key_a     (hit_key_a),
    .hit_key_b     (hit_key_b),
    .hit_preg_lock (hit_preg_lock),
    .code          (code)
  );

  fcd_seq seq_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (wr_en),
    .hit_key_a     (hit_key_a),
    .hit_key_b     (hit_key_b),
    .hit_preg_lock (hit_preg_lock),
    .code          (code),
    .lock_bit      (wr_data[1]),
    .fire          (fire),
    .fire_op       (fire_op),
    .sp_mode       (single_mode)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_op   <= fire_op;
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  // R12: a request only follows a write that was accepted
  a_r12_req_after_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |-> $past(wr_valid && !prog_busy));

  // R12: the request carries the final write's address and data
  a_r12_addr_carried: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |-> (req_addr == $past(wr_addr) && req_data == $past(wr_data)));

  // R10: a write made while busy raises nothing
  a_r10_busy_dropped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && prog_busy) |=> !req_valid);

  // R8: in single-pulse mode every accepted write is a program
  a_r8_single_programs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (single_mode && wr_valid && !prog_busy) |=> (req_valid && req_op == OP_PROGRAM));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 63;

  logic        clk, rst_n, wr_valid, prog_busy;
  logic [19:0] wr_addr;
  logic [15:0] wr_data;
  logic        req_valid, single_mode;
  logic [3:0]  req_op;
  logic [19:0] req_addr;
  logic [15:0] req_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_busy(prog_busy), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .single_mode(single_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {addr, data, busy, expect_valid, expect_op}
  localparam logic [41:0] VECS [0:NV-1] = '{
    // R2 program
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h00A0,1'b0,1'b0,4'd0}, {20'h12345,16'h1234,1'b0,1'b1,4'd1},
    // R1/R3 id entry using 2AA form
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h002AA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h0090,1'b0,1'b1,4'd7},
    // R1/R3 id exit with high address and data bits set
    {20'hFF555,16'hFFAA,1'b0,1'b0,4'd0}, {20'h80AAA,16'h3355,1'b0,1'b0,4'd0},
    {20'h00555,16'h00F0,1'b0,1'b1,4'd8},
    // R4 chip erase
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h0080,1'b0,1'b0,4'd0}, {20'h00555,16'h00AA,1'b0,1'b0,4'd0},
    {20'h00AAA,16'h0055,1'b0,1'b0,4'd0}, {20'h00555,16'h0010,1'b0,1'b1,4'd2},
    // R5 sector erase
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h0080,1'b0,1'b0,4'd0}, {20'h00555,16'h00AA,1'b0,1'b0,4'd0},
    {20'h00AAA,16'h0055,1'b0,1'b0,4'd0}, {20'h48000,16'h0030,1'b0,1'b1,4'd3},
    // R5 sector lock
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h0080,1'b0,1'b0,4'd0}, {20'h00555,16'h00AA,1'b0,1'b0,4'd0},
    {20'h00AAA,16'h0055,1'b0,1'b0,4'd0}, {20'h80000,16'h0060,1'b0,1'b1,4'd4},
    // R6 one-cycle commands
    {20'h00123,16'h00B0,1'b0,1'b1,4'd5}, {20'hC0000,16'h0030,1'b0,1'b1,4'd6},
    {20'h00777,16'h00F0,1'b0,1'b1,4'd8},
    // R7 protection register program
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h00C0,1'b0,1'b0,4'd0}, {20'h00085,16'h1234,1'b0,1'b1,4'd9},
    // R7 protection lock, D1 clear
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h00C0,1'b0,1'b0,4'd0}, {20'h00080,16'h00FD,1'b0,1'b1,4'd10},
    // R11 broken unlock
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00123,16'h0055,1'b0,1'b0,4'd0},
    {20'h00AAA,16'h0055,1'b0,1'b0,4'd0}, {20'h00555,16'h00A0,1'b0,1'b0,4'd0},
    // R10 busy writes dropped
    {20'h00555,16'h00AA,1'b1,1'b0,4'd0}, {20'h00000,16'h00B0,1'b1,1'b0,4'd0},
    {20'h00000,16'h00B0,1'b0,1'b1,4'd5},
    // R10 busy in mid-sequence keeps position
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h00A0,1'b1,1'b0,4'd0}, {20'h00555,16'h0090,1'b0,1'b1,4'd7},
    // R6 suspend inside an unlock pair, pair dropped
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00000,16'h00B0,1'b0,1'b1,4'd5},
    {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    // R8 single-pulse entry then every write programs
    {20'h00555,16'h00AA,1'b0,1'b0,4'd0}, {20'h00AAA,16'h0055,1'b0,1'b0,4'd0},
    {20'h00555,16'h0080,1'b0,1'b0,4'd0}, {20'h00555,16'h00AA,1'b0,1'b0,4'd0},
    {20'h00AAA,16'h0055,1'b0,1'b0,4'd0}, {20'h00555,16'h00A0,1'b0,1'b1,4'd11},
    {20'h00555,16'h00AA,1'b0,1'b1,4'd1}, {20'h00000,16'h00B0,1'b0,1'b1,4'd1},
    {20'h00555,16'h0010,1'b0,1'b1,4'd1}, {20'h00321,16'h00B0,1'b1,1'b0,4'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write, followed by a check of the registered request
  task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic b,
                          input logic ev, input logic [3:0] eop, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; prog_busy = b;
    @(negedge clk);
    wr_valid = 1'b0; prog_busy = 1'b0;
    check({tag, " req_valid"}, 32'(req_valid), 32'(ev));
    if (ev) begin
      check({tag, " req_op"},   32'(req_op),   32'(eop));
      check({tag, " req_addr"}, 32'(req_addr), 32'(a));
      check({tag, " req_data"}, 32'(req_data), 32'(d));
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; prog_busy = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 reset req_valid", 32'(req_valid), 32'd0);
    check("R12 reset single_mode", 32'(single_mode), 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i][41:22], VECS[i][21:6], VECS[i][5], VECS[i][4], VECS[i][3:0],
               $sformatf("R1-vector %0d", i));
    end
    check("R8 single_mode set", 32'(single_mode), 32'd1);

    // R9: only reset leaves single-pulse mode
    repeat (5) @(negedge clk);
    check("R9 single_mode holds", 32'(single_mode), 32'd1);
    apply_reset();
    check("R9 single_mode cleared", 32'(single_mode), 32'd0);
    do_write(20'h00000, 16'h00B0, 1'b0, 1'b1, 4'd5, "R9 suspend after reset");

    // R7: lock address with D1 set raises nothing, then decoder is idle
    do_write(20'h00555, 16'h00AA, 1'b0, 1'b0, 4'd0, "R7 key1");
    do_write(20'h00AAA, 16'h0055, 1'b0, 1'b0, 4'd0, "R7 key2");
    do_write(20'h00555, 16'h00C0, 1'b0, 1'b0, 4'd0, "R7 select");
    do_write(20'h00080, 16'h0002, 1'b0, 1'b0, 4'd0, "R7 D1 set no lock");
    do_write(20'h00085, 16'h5555, 1'b0, 1'b0, 4'd0, "R11 idle after no-op");

    // R11: a wrong selector in the second pair aborts
    do_write(20'h00555, 16'h00AA, 1'b0, 1'b0, 4'd0, "R11 k1");
    do_write(20'h00AAA, 16'h0055, 1'b0, 1'b0, 4'd0, "R11 k2");
    do_write(20'h00555, 16'h0080, 1'b0, 1'b0, 4'd0, "R11 ext");
    do_write(20'h00555, 16'h00AA, 1'b0, 1'b0, 4'd0, "R11 k3");
    do_write(20'h00AAA, 16'h0055, 1'b0, 1'b0, 4'd0, "R11 k4");
    do_write(20'h00555, 16'h0077, 1'b0, 1'b0, 4'd0, "R11 bad sixth");
    do_write(20'h00555, 16'h0010, 1'b0, 1'b0, 4'd0, "R11 no late erase");
    check("R8 no mode after abort", 32'(single_mode), 32'd0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule